// File: doc/BRIEF.md
# Page Load Window and Program Timer

This block gathers the words of one page before a one-time-programmable array is written. The host opens a load window with a one-cycle `arm_i` pulse. Each word is then delivered as a low pulse on `ce_n_i` while `oe_n_i` is high. Both strobes are sampled in the `clk` domain and edge-detected. The falling edge captures the address: the upper 14 bits name the page and the low 6 bits name the word within it. The rising edge captures the data into a 64-entry page buffer and marks that slot valid. Words may come in any order, and a repeated slot keeps its last value.

There is no explicit command to end the load. When no falling edge follows the most recent rising edge within `TIMEOUT_CYC` clock cycles, the window closes. The block then walks the 64 slots once and emits one write on its array write port for each valid slot. Unloaded slots are skipped, so they stay unprogrammed. A modelled programming period of `PROG_CYC` cycles follows, and the block ends it with a one-cycle `done_o`. If a load names a different page from the first one, the load is abandoned and `fail_o` is set. The flag stays set until `clr_fail_i` is pulsed, and while it is set any `arm_i` is ignored.

States: `ST_IDLE` (waiting for arm), `ST_ARMED` (waiting for the first word), `ST_LOAD` (window open), `ST_FLUSH` (slot walk) and `ST_PROG` (programming period). The transitions are:
- idle→armed on an accepted arm.
- armed→load on the first load falling edge.
- load→idle on a page mismatch.
- load→flush on window expiry.
- flush→prog after slot 63.
- prog→idle when the period ends.

Top module: `page_loader`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fail_o` and `wr_en_o` are all 0.
- R2: An `arm_i` pulse in idle with `fail_o` clear makes `busy_o` 1 from the next cycle. `busy_o` stays 1 until the cycle in which `done_o` is 1, and in that cycle `busy_o` is 0.
- R3: A word load is a falling edge of `ce_n_i` sampled with `oe_n_i`=1, followed by a rising edge. A falling edge with `oe_n_i`=0 loads nothing.
- R4: The word offset `addr_i[5:0]` and the page `addr_i[19:6]` are taken at the falling edge. The data is taken at the rising edge. `page_o` shows the page of the first load.
- R5: Words may be loaded in any order. A slot loaded twice keeps the data of its last load.
- R6: Loading stays open while each falling edge arrives fewer than `TIMEOUT_CYC` cycles after the previous rising edge. Once `TIMEOUT_CYC` cycles pass after a rising edge with no falling edge, the window closes and no write occurs before then.
- R7: After the window closes, each loaded slot is written exactly once, with `wr_addr_o` = {page, offset} and its data. A slot never loaded is never written.
- R8: `done_o` is a single-cycle pulse. It rises exactly `PROG_CYC` cycles after the write of slot 63.
- R9: A load whose page differs from the first load's page sets `fail_o` and returns to idle. That load produces no writes and no `done_o`. `fail_o` then holds until `clr_fail_i`.
- R10: While `fail_o` is 1, `arm_i` is ignored and `busy_o` stays 0. A `clr_fail_i` pulse clears `fail_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm_i | input | 1 | Opens a load window (program command accepted) |
| clr_fail_i | input | 1 | Clears the fail flag |
| ce_n_i | input | 1 | Chip-enable strobe, active low |
| oe_n_i | input | 1 | Output enable, must be high for a load |
| addr_i | input | 20 | Word address, page in [19:6], offset in [5:0] |
| data_i | input | 16 | Word data, taken at strobe rising edge |
| wr_en_o | output | 1 | Array write strobe |
| wr_addr_o | output | 20 | Array write address |
| wr_data_o | output | 16 | Array write data |
| page_o | output | 14 | Page being loaded or programmed |
| busy_o | output | 1 | Load or program in progress |
| done_o | output | 1 | One-cycle end-of-program pulse |
| fail_o | output | 1 | Sticky page-mismatch flag |

## Verification
The main function is first driven from a table of eight loads in scrambled order. The table includes the top and bottom slots and one repeated slot, which separates a correct slot map from one that orders, drops or keeps the first copy. In every load the address is changed between the two edges and the data is corrupted until the rising edge, which shows whether each field is taken at its own edge. A second pattern puts a falling edge with output enable low between loads and leaves a gap just under the timeout, which distinguishes an ignored strobe and an extended window from premature closing. A third pattern switches page in mid-load and then tries to re-arm with the flag set, which exercises the abort and lockout paths.

// File: rtl/pl_pkg.sv
package pl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_LOAD,
        ST_FLUSH,
        ST_PROG
    } pl_state_e;

endpackage

// File: rtl/ce_edge.sv
module ce_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_i,
    output logic fall_o,
    output logic rise_o
);
    logic ce_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ce_q <= 1'b1;
        else        ce_q <= ce_n_i;
    end

    assign fall_o = ce_q & ~ce_n_i;
    assign rise_o = ~ce_q & ce_n_i;

    // A falling edge leaves the strobe low, so no second fall can follow at once
    AST_NO_DOUBLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o); // R3

endmodule

// File: rtl/span_timer.sv
module span_timer #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic run_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (restart_i)            cnt_q <= '0;
        else if (run_i && !expired_o)  cnt_q <= cnt_q + 1'b1;
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(LIMIT)); // R6

endmodule

// File: rtl/word_store.sv
module word_store #(
    parameter int DATA_W = 16,
    parameter int OFS_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              we_i,
    input  logic [OFS_W-1:0]  waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [OFS_W-1:0]  raddr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rvalid_o
);
    localparam int WORDS = 1 << OFS_W;

    logic [DATA_W-1:0] mem_q [WORDS];
    logic [WORDS-1:0]  valid_q;

    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_valid
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                       valid_q[g] <= 1'b0;
            else if (clear_i)                                 valid_q[g] <= 1'b0;
            else if (we_i && (waddr_i == OFS_W'(g)))          valid_q[g] <= 1'b1;
        end
    end

    assign rdata_o  = mem_q[raddr_i];
    assign rvalid_o = valid_q[raddr_i];

    AST_SLOT_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !clear_i) |=> valid_q[$past(waddr_i)]); // R7

endmodule

// File: rtl/page_loader.sv
module page_loader #(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 16,
    parameter int OFS_W       = 6,
    parameter int TIMEOUT_CYC = 32,
    parameter int PROG_CYC    = 40
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      arm_i,
    input  logic                      clr_fail_i,
    input  logic                      ce_n_i,
    input  logic                      oe_n_i,
    input  logic [ADDR_W-1:0]         addr_i,
    input  logic [DATA_W-1:0]         data_i,
    output logic                      wr_en_o,
    output logic [ADDR_W-1:0]         wr_addr_o,
    output logic [DATA_W-1:0]         wr_data_o,
    output logic [ADDR_W-OFS_W-1:0]   page_o,
    output logic                      busy_o,
    output logic                      done_o,
    output logic                      fail_o
);
    import pl_pkg::*;

    localparam int PAGE_W = ADDR_W - OFS_W;
    localparam logic [OFS_W-1:0] IDX_LAST = {OFS_W{1'b1}};

    pl_state_e state_q, state_d;

    logic              ce_fall, ce_rise, load_fall, page_bad;
    logic              win_run, win_exp, prog_go, prog_exp;
    logic              st_we, st_clear, st_rvalid;
    logic [DATA_W-1:0] st_rdata;

    logic [PAGE_W-1:0] page_q;
    logic [OFS_W-1:0]  ofs_q;
    logic [OFS_W-1:0]  idx_q;
    logic              pulse_q;
    logic              fail_q;
    logic              done_q;
    logic              wr_en_q;
    logic [ADDR_W-1:0] wr_addr_q;
    logic [DATA_W-1:0] wr_data_q;

    ce_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n_i (ce_n_i),
        .fall_o (ce_fall),
        .rise_o (ce_rise)
    );

    assign load_fall = ce_fall && oe_n_i;
    assign page_bad  = addr_i[ADDR_W-1:OFS_W] != page_q;

    assign win_run = (state_q == ST_LOAD) && !pulse_q;
    assign prog_go = (state_q == ST_FLUSH) && (idx_q == IDX_LAST);

    span_timer #(.LIMIT(TIMEOUT_CYC)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (ce_rise),
        .run_i     (win_run),
        .expired_o (win_exp)
    );

    span_timer #(.LIMIT(PROG_CYC)) u_period (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (prog_go),
        .run_i     (state_q == ST_PROG),
        .expired_o (prog_exp)
    );

    assign st_we    = (state_q == ST_LOAD) && ce_rise && pulse_q;
    assign st_clear = (state_q == ST_IDLE) && arm_i && !fail_q;

    word_store #(.DATA_W(DATA_W), .OFS_W(OFS_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (st_clear),
        .we_i     (st_we),
        .waddr_i  (ofs_q),
        .wdata_i  (data_i),
        .raddr_i  (idx_q),
        .rdata_o  (st_rdata),
        .rvalid_o (st_rvalid)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (arm_i && !fail_q) state_d = ST_ARMED;
            ST_ARMED: if (load_fall)        state_d = ST_LOAD;
            ST_LOAD: begin
                if (load_fall && page_bad)  state_d = ST_IDLE;
                else if (!load_fall && win_exp) state_d = ST_FLUSH;
            end
            ST_FLUSH: if (idx_q == IDX_LAST) state_d = ST_PROG;
            ST_PROG:  if (prog_exp)          state_d = ST_IDLE;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page_q    <= '0;
            ofs_q     <= '0;
            idx_q     <= '0;
            pulse_q   <= 1'b0;
            fail_q    <= 1'b0;
            done_q    <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else begin
            done_q  <= 1'b0;
            wr_en_q <= 1'b0;
            if (clr_fail_i) fail_q <= 1'b0;
            if (state_q == ST_IDLE) begin
                idx_q   <= '0;
                pulse_q <= 1'b0;
            end else if (state_q == ST_ARMED) begin
                if (load_fall) begin
                    page_q  <= addr_i[ADDR_W-1:OFS_W];
                    ofs_q   <= addr_i[OFS_W-1:0];
                    pulse_q <= 1'b1;
                end
            end else if (state_q == ST_LOAD) begin
                if (load_fall && page_bad) begin
                    fail_q  <= 1'b1;
                    pulse_q <= 1'b0;
                end else if (load_fall) begin
                    ofs_q   <= addr_i[OFS_W-1:0];
                    pulse_q <= 1'b1;
                end else if (ce_rise) begin
                    pulse_q <= 1'b0;
                end
            end else if (state_q == ST_FLUSH) begin
                wr_en_q   <= st_rvalid;
                wr_addr_q <= {page_q, idx_q};
                wr_data_q <= st_rdata;
                idx_q     <= idx_q + 1'b1;
            end else if (state_q == ST_PROG) begin
                if (prog_exp) done_q <= 1'b1;
            end
        end
    end

    assign wr_en_o   = wr_en_q;
    assign wr_addr_o = wr_addr_q;
    assign wr_data_o = wr_data_q;
    assign page_o    = page_q;
    assign busy_o    = state_q != ST_IDLE;
    assign done_o    = done_q;
    assign fail_o    = fail_q;

    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> busy_o); // R7
    AST_WRITE_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_addr_o[ADDR_W-1:OFS_W] == page_o)); // R7
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R2
    AST_FAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !clr_fail_i) |=> fail_o); // R9
    AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> !wr_en_o); // R9
    AST_ARM_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && fail_o && arm_i) |=> !busy_o); // R10
    AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FLUSH) |=> $stable(page_o)); // R4

endmodule

// File: tb/sim_page_loader.sv
module sim_page_loader;
    localparam int CLK_PERIOD = 10;
    localparam int TO         = 32;
    localparam int PC         = 40;
    localparam int NVEC       = 8;
    localparam logic [13:0] PAGE_A = 14'h2A5A;
    localparam logic [13:0] PAGE_B = 14'h0133;

    // {offset[5:0], data[15:0]}, loaded in this order
    localparam logic [21:0] VEC [NVEC] = '{
        {6'd5,  16'h1111}, {6'd0,  16'h2222}, {6'd63, 16'h3333}, {6'd17, 16'h4444},
        {6'd5,  16'hAAAA}, {6'd32, 16'h5555}, {6'd1,  16'h6666}, {6'd62, 16'h7777}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0, clr = 1'b0, ce_n = 1'b1, oe_n = 1'b1;
    logic [19:0] addr = '0;
    logic [15:0] data = '0;
    logic        wr_en, busy, done, fail;
    logic [19:0] wr_addr;
    logic [15:0] wr_data;
    logic [13:0] page;

    int checks = 0, errors = 0, cyc = 0;
    int wr_cnt = 0, done_cnt = 0, last_wr_cyc = 0, done_cyc = 0;
    int          seen_n [64];
    logic [15:0] seen_d [64];
    logic [19:0] seen_a [64];
    bit          exp_v [64];
    logic [15:0] exp_d [64];

    page_loader #(.TIMEOUT_CYC(TO), .PROG_CYC(PC)) u0 (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .clr_fail_i(clr),
        .ce_n_i(ce_n), .oe_n_i(oe_n), .addr_i(addr), .data_i(data),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .page_o(page), .busy_o(busy), .done_o(done), .fail_o(fail)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: act %0d exp <150000 cycles", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (wr_en) begin
            wr_cnt = wr_cnt + 1;
            seen_n[wr_addr[5:0]] = seen_n[wr_addr[5:0]] + 1;
            seen_d[wr_addr[5:0]] = wr_data;
            seen_a[wr_addr[5:0]] = wr_addr;
            last_wr_cyc = cyc;
        end
        if (done) begin
            done_cnt = done_cnt + 1;
            done_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: act %0h exp %0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int i = 0; i < 64; i++) begin
            seen_n[i] = 0; seen_d[i] = '0; seen_a[i] = '0; exp_v[i] = 1'b0; exp_d[i] = '0;
        end
        wr_cnt = 0; done_cnt = 0;
    endtask

    task automatic arm_pulse();
        arm = 1'b1; @(negedge clk); arm = 1'b0;
    endtask

    // Address valid only around the falling edge, data valid only at the rising edge
    task automatic ce_pulse(input logic [13:0] pg, input logic [5:0] ofs, input logic [15:0] d, input logic oe);
        oe_n = oe; addr = {pg, ofs}; data = ~d; ce_n = 1'b0;
        @(negedge clk);
        addr = {pg, ofs ^ 6'h2A};
        @(negedge clk);
        data = d; ce_n = 1'b1;
        @(negedge clk);
        data = 16'hDEAD; oe_n = 1'b1;
    endtask

    task automatic wait_done(input int lim);
        for (int i = 0; i < lim; i++) begin
            if (done_cnt != 0) break;
            @(negedge clk);
        end
    endtask

    initial begin
        clear_log();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy", busy, 0);
        chk(fail == 0 && done == 0 && wr_en == 0, "R1 flags", {fail, done, wr_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: scrambled order, repeated slot, edge-split fields
        arm_pulse();
        chk(busy == 1, "R2 busy after arm", busy, 1);
        for (int v = 0; v < NVEC; v++) begin
            ce_pulse(PAGE_A, VEC[v][21:16], VEC[v][15:0], 1'b1);
            exp_v[VEC[v][21:16]] = 1'b1;
            exp_d[VEC[v][21:16]] = VEC[v][15:0];
        end
        chk(page == PAGE_A, "R4 page latched", page, PAGE_A);
        wait_done(TO + 64 + PC + 20);
        chk(done_cnt == 1, "R8 done pulse", done_cnt, 1);
        chk(busy == 0, "R2 busy cleared", busy, 0);
        chk(done_cyc - last_wr_cyc == PC, "R8 period length", done_cyc - last_wr_cyc, PC);
        chk(wr_cnt == 7, "R7 write count", wr_cnt, 7);
        for (int s = 0; s < 64; s++) begin
            if (exp_v[s]) begin
                chk(seen_n[s] == 1, "R7 slot written once", seen_n[s], 1);
                chk(seen_d[s] == exp_d[s], "R5 R4 slot data", seen_d[s], exp_d[s]);
                chk(seen_a[s] == {PAGE_A, 6'(s)}, "R7 write address", seen_a[s], {PAGE_A, 6'(s)});
            end else begin
                chk(seen_n[s] == 0, "R7 unloaded slot skipped", seen_n[s], 0);
            end
        end

        // Ignored strobe with output enable low, gap just under timeout
        clear_log();
        @(negedge clk);
        arm_pulse();
        ce_pulse(PAGE_B, 6'd3, 16'hBEEF, 1'b1);
        ce_pulse(PAGE_B, 6'd4, 16'h0BAD, 1'b0);
        repeat (TO - 4) @(negedge clk);
        chk(busy == 1 && wr_cnt == 0, "R6 window still open", wr_cnt, 0);
        ce_pulse(PAGE_B, 6'd9, 16'hC0DE, 1'b1);
        repeat (TO - 2) @(negedge clk);
        chk(wr_cnt == 0, "R6 no write before expiry", wr_cnt, 0);
        wait_done(64 + PC + 20);
        chk(done_cnt == 1, "R6 window closed", done_cnt, 1);
        chk(seen_n[4] == 0, "R3 oe-low strobe ignored", seen_n[4], 0);
        chk(seen_n[3] == 1 && seen_d[3] == 16'hBEEF, "R3 slot 3", seen_d[3], 16'hBEEF);
        chk(seen_n[9] == 1 && seen_d[9] == 16'hC0DE, "R6 late word kept", seen_d[9], 16'hC0DE);

        // Page mismatch
        clear_log();
        arm_pulse();
        ce_pulse(PAGE_A, 6'd7, 16'h1234, 1'b1);
        ce_pulse(PAGE_B, 6'd8, 16'h5678, 1'b1);
        chk(fail == 1, "R9 fail set", fail, 1);
        chk(busy == 0, "R9 back to idle", busy, 0);
        repeat (TO + 64 + PC + 10) @(negedge clk);
        chk(wr_cnt == 0 && done_cnt == 0, "R9 no write no done", wr_cnt + done_cnt, 0);
        chk(fail == 1, "R9 fail sticky", fail, 1);

        // Arm while failed, then clear
        arm_pulse();
        @(negedge clk);
        chk(busy == 0, "R10 arm ignored", busy, 0);
        clr = 1'b1; @(negedge clk); clr = 1'b0;
        chk(fail == 0, "R10 fail cleared", fail, 0);
        arm_pulse();
        chk(busy == 1, "R10 arm accepted", busy, 1);
        ce_pulse(PAGE_B, 6'd0, 16'h0F0F, 1'b1);
        wait_done(TO + 64 + PC + 20);
        chk(done_cnt == 1 && seen_d[0] == 16'h0F0F, "R10 recovery run", seen_d[0], 16'h0F0F);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule